// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block connects a synchronous request port to an external asynchronous static RAM of 256K bytes. The RAM has an active-low select, an active-high select, an active-low output enable and an active-low write enable. A client presents one byte request at a time, either a read or a write, with an 18-bit address. The controller then sequences the RAM pins and stretches each phase over enough clock cycles to respect the RAM's minimum timing. The shared data bus is handled as three separate signals: a value to drive, an enable for that drive, and the value sampled from the pins.

Every minimum interval is turned into a whole number of clock cycles at elaboration time. The inputs to that conversion are the clock period parameter and a speed grade parameter. Write cycles are timed by the write-enable pulse, with both selects held asserted. A read returns its byte through a one-cycle valid pulse. After each access the controller stays busy until the full cycle time has passed. While idle it keeps the RAM deselected.

Top module: `sram_async_ctrl`

## Requirements
- R1: While idle, and straight after reset, `req_ready` is 1 and the RAM is deselected: `mem_cs1_n`=1, `mem_cs2`=0, `mem_oe_n`=1, `mem_we_n`=1, `mem_dq_oe`=0 and `rd_valid`=0.
- R2: A request is taken only on a clock edge where both `req_valid` and `req_ready` are 1. `req_ready` falls on the edge after that. A request presented while `req_ready` is 0 is ignored, and the RAM contents do not change because of it.
- R3: `mem_we_n` is low only while the RAM is selected (`mem_cs1_n`=0, `mem_cs2`=1) and `mem_oe_n`=1. Each low pulse lasts max(tWP, tDW) in cycles, and lasts long enough that address valid to write end covers tAW. At the defaults this is 6 cycles.
- R4: `mem_dq_oe` is 1 only while `mem_oe_n`=1. Before the write pulse, the drive is held off for max(tWHZ, tOHZ) in cycles, and `mem_addr` and `mem_dq_out` stay unchanged through the rising edge of `mem_we_n`.
- R5: A read holds `mem_oe_n` low with the drive off for max(tAA, tOE) in cycles. It captures `mem_dq_in` on the edge that ends that wait. It then pulses `rd_valid` for exactly one cycle with the byte on `rd_data`. At the defaults `rd_valid` rises 7 cycles after the accepting edge.
- R6: After acceptance, `req_ready` stays 0 for at least the tRC count. A write is busy for release + pulse + 1 cycles (10 at the defaults). A read is busy for max(read wait, tRC count) cycles (7 at the defaults).
- R7: Each interval in cycles is ceil(ns / `CLK_PERIOD_NS`), with a minimum of 1. `SPEED_GRADE`=0 selects tRC=tAA=55, tOE=30, tWP=45, tAW=45, tDW=25, tWHZ=tOHZ=20 ns. `SPEED_GRADE`=1 selects 70, 70, 35, 55, 60, 30, 25 ns in the same order.
- R8: A byte written to any address, including 0x00000 and 0x3FFFF, reads back unchanged, and writes to other addresses do not disturb it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write byte |
| req_ready | output | 1 | Controller idle; a request is taken on this edge |
| rd_valid | output | 1 | One-cycle read completion pulse |
| rd_data | output | DATA_W | Read byte, valid with rd_valid |
| mem_addr | output | ADDR_W | RAM address pins |
| mem_cs1_n | output | 1 | RAM select, active low |
| mem_cs2 | output | 1 | RAM select, active high |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_dq_out | output | DATA_W | Value to drive onto the data pins |
| mem_dq_oe | output | 1 | Enable for the data pin drivers |
| mem_dq_in | input | DATA_W | Value sampled from the data pins |

## Verification
Isolated writes and reads at the lowest and highest addresses, with all-zero, all-one and alternating bit patterns, show that the address and data paths carry every bit. Write-then-read pairs at scattered addresses, issued back to back, test the turnaround from a read's output enable to the write drivers. A request held while the controller is busy, followed by a read of its target, tells apart ignoring that request from accepting it late. The RAM model returns the bitwise inverse of the stored byte until tAA and tOE have both elapsed, so capturing one cycle early shows up as a data mismatch. Counting cycles of write-enable low, accept-to-valid and busy separates correct rounding from off-by-one phase lengths.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
// Shared types and elaboration-time timing helpers for the asynchronous
// SRAM controller. Assumes all times are whole nanoseconds.
package sram_ctrl_pkg;

    // Sequencer phases
    typedef enum logic [2:0] {
        ST_IDLE,   // deselected, ready for a request
        ST_WREL,   // write: selected, OE high, waiting for bus release
        ST_WPUL,   // write: WE low, data driven
        ST_WEND,   // write: WE high again, address/data still held
        ST_RACC,   // read: OE low, waiting for valid data
        ST_GAP     // deselected, padding out the cycle time
    } seq_st_e;

    // Timing quantities kept per speed grade
    typedef enum int {
        T_CYC, T_ACC, T_OEV, T_WPW, T_ADW, T_DSU, T_WRZ, T_OFZ
    } tim_e;

    // Minimum (or maximum release) time in ns for a grade: 0 fast, 1 slow
    function automatic int grade_ns(input int grade, input tim_e k);
        int v;
        case (k)
            T_CYC:   v = (grade == 0) ? 55 : 70;
            T_ACC:   v = (grade == 0) ? 55 : 70;
            T_OEV:   v = (grade == 0) ? 30 : 35;
            T_WPW:   v = (grade == 0) ? 45 : 55;
            T_ADW:   v = (grade == 0) ? 45 : 60;
            T_DSU:   v = (grade == 0) ? 25 : 30;
            T_WRZ:   v = (grade == 0) ? 20 : 25;
            default: v = (grade == 0) ? 20 : 25;
        endcase
        return v;
    endfunction

    // Round a duration up to whole clock cycles, never below one
    function automatic int to_cycles(input int ns, input int period);
        int c;
        c = (ns + period - 1) / period;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
// Loadable down-counter timing the length of each sequencer phase.
// Assumes: load value is (phase length - 1); done is high when the count is 0.
module sram_phase_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt;

    // Load on phase entry, otherwise count down to zero and stop
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/sram_seq_fsm.sv
`timescale 1ns/1ps
// Access sequencer: walks through the write or read phases and loads the
// phase timer on every transition. Assumes each phase count is >= 1 and
// that a gap count of 0 means the gap phase is skipped.
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int CW    = 4,
    parameter int N_REL = 3,
    parameter int N_WPD = 6,
    parameter int N_RD  = 7,
    parameter int GAP_W = 0,
    parameter int GAP_R = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          tmr_done,
    output seq_st_e       st,
    output logic          ready,
    output logic          accept,
    output logic          capture,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val
);
    seq_st_e nxt;

    // Next phase and timer load selection
    always_comb begin
        nxt      = st;
        accept   = 1'b0;
        capture  = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (st)
            ST_IDLE: begin
                if (req_valid) begin
                    accept   = 1'b1;
                    tmr_load = 1'b1;
                    if (req_write) begin
                        nxt     = ST_WREL;
                        tmr_val = CW'(N_REL - 1);
                    end else begin
                        nxt     = ST_RACC;
                        tmr_val = CW'(N_RD - 1);
                    end
                end
            end
            ST_WREL: begin
                if (tmr_done) begin
                    nxt      = ST_WPUL;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(N_WPD - 1);
                end
            end
            ST_WPUL: begin
                if (tmr_done) begin
                    nxt      = ST_WEND;
                    tmr_load = 1'b1;
                    tmr_val  = '0;
                end
            end
            ST_WEND: begin
                if (GAP_W > 0) begin
                    nxt      = ST_GAP;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(GAP_W - 1);
                end else begin
                    nxt = ST_IDLE;
                end
            end
            ST_RACC: begin
                if (tmr_done) begin
                    capture = 1'b1;
                    if (GAP_R > 0) begin
                        nxt      = ST_GAP;
                        tmr_load = 1'b1;
                        tmr_val  = CW'(GAP_R - 1);
                    end else begin
                        nxt = ST_IDLE;
                    end
                end
            end
            ST_GAP: begin
                if (tmr_done) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    assign ready = (st == ST_IDLE);
endmodule

// File: rtl/sram_pin_drive.sv
`timescale 1ns/1ps
// Pin stage: latches the request on acceptance, decodes the RAM control
// pins from the current phase and captures read data. Assumes accept and
// capture are single-cycle strobes from the sequencer.
module sram_pin_drive
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_st_e           st,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs1_n,
    output logic              mem_cs2,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    logic sel;

    // Hold address and write byte for the whole access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
        end else if (accept) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
        end
    end

    // Capture read byte and raise the one-cycle completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= capture;
            if (capture) rd_data <= mem_dq_in;
        end
    end

    // Control pins follow the phase
    always_comb begin
        sel       = (st != ST_IDLE) && (st != ST_GAP);
        mem_cs1_n = !sel;
        mem_cs2   = sel;
        mem_oe_n  = (st != ST_RACC);
        mem_we_n  = (st != ST_WPUL);
        mem_dq_oe = (st == ST_WPUL) || (st == ST_WEND);
    end
endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
// Asynchronous SRAM controller top. Converts the grade's minimum times to
// cycle counts and wires the sequencer, phase timer and pin stage.
// Assumes one outstanding request at a time and an external bus buffer
// controlled by mem_dq_oe.
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 8,
    parameter int SPEED_GRADE   = 0,
    parameter int ADDR_W        = 18,
    parameter int DATA_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs1_n,
    output logic              mem_cs2,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int N_RC  = to_cycles(grade_ns(SPEED_GRADE, T_CYC), CLK_PERIOD_NS);
    localparam int N_AA  = to_cycles(grade_ns(SPEED_GRADE, T_ACC), CLK_PERIOD_NS);
    localparam int N_OE  = to_cycles(grade_ns(SPEED_GRADE, T_OEV), CLK_PERIOD_NS);
    localparam int N_WP  = to_cycles(grade_ns(SPEED_GRADE, T_WPW), CLK_PERIOD_NS);
    localparam int N_AW  = to_cycles(grade_ns(SPEED_GRADE, T_ADW), CLK_PERIOD_NS);
    localparam int N_DW  = to_cycles(grade_ns(SPEED_GRADE, T_DSU), CLK_PERIOD_NS);
    localparam int N_WHZ = to_cycles(grade_ns(SPEED_GRADE, T_WRZ), CLK_PERIOD_NS);
    localparam int N_OHZ = to_cycles(grade_ns(SPEED_GRADE, T_OFZ), CLK_PERIOD_NS);

    localparam int N_REL  = max2(N_WHZ, N_OHZ);
    localparam int N_AWR  = (N_AW > N_REL) ? (N_AW - N_REL) : 1;
    localparam int N_WPD  = max2(max2(N_WP, N_DW), N_AWR);
    localparam int N_RD   = max2(N_AA, N_OE);
    localparam int N_WTOT = N_REL + N_WPD + 1;
    localparam int GAP_W  = (N_RC > N_WTOT) ? (N_RC - N_WTOT) : 0;
    localparam int GAP_R  = (N_RC > N_RD) ? (N_RC - N_RD) : 0;
    localparam int N_MAX  = max2(max2(N_RD, N_WPD), max2(N_REL, max2(GAP_W, GAP_R)));
    localparam int CW     = $clog2(N_MAX + 1);

    seq_st_e       st;
    logic          accept;
    logic          capture;
    logic          tmr_load;
    logic          tmr_done;
    logic [CW-1:0] tmr_val;

    sram_seq_fsm #(
        .CW(CW), .N_REL(N_REL), .N_WPD(N_WPD), .N_RD(N_RD),
        .GAP_W(GAP_W), .GAP_R(GAP_R)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .tmr_done(tmr_done), .st(st), .ready(req_ready), .accept(accept),
        .capture(capture), .tmr_load(tmr_load), .tmr_val(tmr_val)
    );

    sram_phase_timer #(.CW(CW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
    );

    sram_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .clk(clk), .rst_n(rst_n), .st(st), .accept(accept), .capture(capture),
        .req_addr(req_addr), .req_wdata(req_wdata), .mem_dq_in(mem_dq_in),
        .mem_addr(mem_addr), .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .rd_data(rd_data), .rd_valid(rd_valid)
    );
endmodule

// File: rtl/sram_async_ctrl_chk.sv
`timescale 1ns/1ps
// Protocol checker for the asynchronous SRAM controller, bound to the top.
// Assumes the same timing parameters as the bound instance.
module sram_async_ctrl_chk
    import sram_ctrl_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 8,
    parameter int SPEED_GRADE   = 0,
    parameter int ADDR_W        = 18,
    parameter int DATA_W        = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs1_n,
    input logic              mem_cs2,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_oe
);
    localparam int C_WP = to_cycles(grade_ns(SPEED_GRADE, T_WPW), CLK_PERIOD_NS);
    localparam int C_RC = to_cycles(grade_ns(SPEED_GRADE, T_CYC), CLK_PERIOD_NS);

    int we_cnt;
    int acc_gap;

    // Length of the current write-enable low pulse
    always_ff @(posedge clk) begin
        if (!rst_n)         we_cnt <= 0;
        else if (!mem_we_n) we_cnt <= we_cnt + 1;
        else                we_cnt <= 0;
    end

    // Cycles since the last accepted request, saturating at the cycle count
    always_ff @(posedge clk) begin
        if (!rst_n)                       acc_gap <= C_RC;
        else if (req_valid && req_ready)  acc_gap <= 1;
        else if (acc_gap < C_RC)          acc_gap <= acc_gap + 1;
    end

    p_idle_deselect_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cs1_n && !mem_cs2 && mem_we_n && mem_oe_n && !mem_dq_oe));

    p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_we_selected_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_cs1_n && mem_cs2 && mem_oe_n));

    p_we_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_cnt >= C_WP));

    p_no_contention_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr));

    p_data_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> ($stable(mem_dq_out) && $stable(mem_addr) && mem_dq_oe));

    p_rd_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    p_cycle_time_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> (acc_gap >= C_RC));
endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
    .CLK_PERIOD_NS(CLK_PERIOD_NS), .SPEED_GRADE(SPEED_GRADE),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .rd_valid(rd_valid), .mem_addr(mem_addr), .mem_cs1_n(mem_cs1_n),
    .mem_cs2(mem_cs2), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_beh_model.sv
`timescale 1ns/1ps
// Behavioural asynchronous RAM partner for the bench. Counts every
// minimum-time violation; returns inverted data until access is complete.
module sram_beh_model #(
    parameter int  GRADE = 0,
    parameter real HALF  = 4.0
) (
    input  logic        clk,
    input  logic [17:0] addr,
    input  logic        cs1_n,
    input  logic        cs2,
    input  logic        oe_n,
    input  logic        we_n,
    input  logic [7:0]  drv,
    input  logic        drv_en,
    output logic [7:0]  dq_rd,
    output int          viol
);
    real t_rc, t_aa, t_oe, t_wp, t_dw, t_aw, t_ohz;
    real t_sel, t_adr, t_oef, t_oer, t_dat, t_ws;
    logic [7:0] store [int];
    logic sel_p, oe_p, en_p, wr_p;
    logic [17:0] addr_p;
    logic [7:0]  drv_p;

    initial begin
        t_rc  = (GRADE == 0) ? 55.0 : 70.0;
        t_aa  = t_rc;
        t_oe  = (GRADE == 0) ? 30.0 : 35.0;
        t_wp  = (GRADE == 0) ? 45.0 : 55.0;
        t_dw  = (GRADE == 0) ? 25.0 : 30.0;
        t_aw  = (GRADE == 0) ? 45.0 : 60.0;
        t_ohz = (GRADE == 0) ? 20.0 : 25.0;
        t_sel = -1000.0; t_adr = 0.0; t_oef = 0.0; t_oer = -1000.0;
        t_dat = 0.0; t_ws = 0.0;
        sel_p = 0; oe_p = 1; en_p = 0; wr_p = 0; addr_p = '0; drv_p = '0;
        viol = 0; dq_rd = '0;
    end

    // Timing checks just after each rising edge, when the controller pins settle
    always @(posedge clk) begin
        real t;
        logic sel, wr;
        #1;
        t   = $realtime - 1.0;
        sel = !cs1_n && cs2;
        wr  = sel && !we_n;
        if (sel && !sel_p) begin
            if (t - t_sel < t_rc) begin viol++; $display("model: cycle time short at %0t", $time); end
            t_sel = t; t_adr = t;
        end
        if (addr != addr_p) begin
            if (wr_p) begin viol++; $display("model: address moved in write at %0t", $time); end
            t_adr = t;
        end
        if (!oe_n && oe_p) t_oef = t;
        if (oe_n && !oe_p) t_oer = t;
        if (drv_en && !en_p) begin
            if (t - t_oer < t_ohz) begin viol++; $display("model: drive before release at %0t", $time); end
            t_dat = t;
        end
        if (drv_en && drv != drv_p) t_dat = t;
        if (drv_en && sel && !oe_n && we_n) begin viol++; $display("model: bus fight at %0t", $time); end
        if (wr && !wr_p) t_ws = t;
        if (!wr && wr_p) begin
            if (t - t_ws < t_wp)  begin viol++; $display("model: write pulse short at %0t", $time); end
            if (!en_p || t - t_dat < t_dw) begin viol++; $display("model: data setup short at %0t", $time); end
            if (t - t_adr < t_aw) begin viol++; $display("model: address setup short at %0t", $time); end
            store[int'(addr_p)] = drv_p;
        end
        sel_p = sel; oe_p = oe_n; en_p = drv_en; wr_p = wr; addr_p = addr; drv_p = drv;
    end

    // Read data update ahead of the next rising edge
    always @(negedge clk) begin
        logic [7:0] v;
        real nxt;
        v   = store.exists(int'(addr)) ? store[int'(addr)] : 8'h00;
        nxt = $realtime + HALF;
        if (!cs1_n && cs2 && !oe_n && we_n && nxt >= t_adr + t_aa && nxt >= t_oef + t_oe)
            dq_rd = v;
        else
            dq_rd = ~v;
    end
endmodule

// File: tb/test_sram_async_ctrl.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected read bytes, a monitor pops
// and compares them, and measures phase lengths at the ports.
module test_sram_async_ctrl;
    localparam int P  = 8;
    localparam int SG = 0;

    function automatic int cyc(input int ns);
        int c;
        c = (ns + P - 1) / P;
        return (c < 1) ? 1 : c;
    endfunction

    // Expected counts from R7 numbers for the fast grade
    localparam int E_REL = (cyc(20) > cyc(20)) ? cyc(20) : cyc(20);
    localparam int E_WPD = (cyc(45) > cyc(25)) ? cyc(45) : cyc(25);
    localparam int E_RD  = (cyc(55) > cyc(30)) ? cyc(55) : cyc(30);
    localparam int E_WB  = (E_REL + E_WPD + 1 > cyc(55)) ? E_REL + E_WPD + 1 : cyc(55);
    localparam int E_RB  = (E_RD > cyc(55)) ? E_RD : cyc(55);

    logic clk = 0;
    logic rst_n = 0;
    logic req_valid = 0, req_write = 0;
    logic [17:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic req_ready, rd_valid;
    logic [7:0] rd_data;
    logic [17:0] mem_addr;
    logic mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0] mem_dq_out, mem_dq_in;
    int viol;

    always #4 clk = ~clk;

    sram_async_ctrl #(.CLK_PERIOD_NS(P), .SPEED_GRADE(SG)) i_sram_async_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
        .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    sram_beh_model #(.GRADE(SG), .HALF(4.0)) u_ram (
        .clk(clk), .addr(mem_addr), .cs1_n(mem_cs1_n), .cs2(mem_cs2),
        .oe_n(mem_oe_n), .we_n(mem_we_n), .drv(mem_dq_out), .drv_en(mem_dq_oe),
        .dq_rd(mem_dq_in), .viol(viol)
    );

    logic [7:0] ref_mem [int];
    logic [7:0] exp_q [$];
    int n_chk = 0, n_err = 0;   // main-thread counters
    int m_chk = 0, m_err = 0;   // monitor counters
    int cycle = 0;
    bit done = 0;

    always @(posedge clk) cycle <= cycle + 1;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic wr, input logic [17:0] a, input logic [7:0] d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic do_write(input logic [17:0] a, input logic [7:0] d);
        ref_mem[int'(a)] = d;
        issue(1'b1, a, d);
    endtask

    task automatic do_read(input logic [17:0] a);
        exp_q.push_back(ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00);
        issue(1'b0, a, 8'h00);
    endtask

    // Monitor: scoreboard compare, read latency, WE width, busy length, bus fight
    int acc_cyc = 0, busy = 0, we_lo = 0, fights = 0;
    bit acc_wr = 0, in_busy = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_valid) begin
                m_chk++;
                if (exp_q.size() == 0) begin
                    m_err++; $display("FAIL R5: unexpected rd_valid, got %0h expected none", rd_data);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    if (rd_data !== e) begin
                        m_err++; $display("FAIL R8: read data got %0h expected %0h", rd_data, e);
                    end
                end
                m_chk++;   // R5 and R7 latency from accept to rd_valid
                if (cycle - acc_cyc - 1 != E_RD) begin
                    m_err++; $display("FAIL R5/R7: read latency got %0d expected %0d", cycle - acc_cyc - 1, E_RD);
                end
            end
            if (!mem_we_n) we_lo++;
            else if (we_lo > 0) begin
                m_chk++;   // R3 write pulse width
                if (we_lo != E_WPD) begin
                    m_err++; $display("FAIL R3: WE low cycles got %0d expected %0d", we_lo, E_WPD);
                end
                we_lo = 0;
            end
            if (mem_dq_oe && !mem_oe_n) fights++;
            if (in_busy && req_ready) begin
                m_chk++;   // R6 busy length
                if (busy != (acc_wr ? E_WB : E_RB)) begin
                    m_err++; $display("FAIL R6: busy cycles got %0d expected %0d", busy, acc_wr ? E_WB : E_RB);
                end
                in_busy = 0;
            end
            if (!req_ready) busy++;
            if (req_valid && req_ready) begin
                acc_cyc = cycle; acc_wr = req_write; busy = 0; in_busy = 1;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk + m_chk + 1, n_err + m_err + 1);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1;
        @(negedge clk);
        // R1 reset/idle pin state
        check("R1 ready", req_ready, 1);
        check("R1 selects", {mem_cs1_n, mem_cs2}, 2'b10);
        check("R1 oe/we/drive", {mem_oe_n, mem_we_n, mem_dq_oe, rd_valid}, 4'b1100);

        // R8 edge addresses and patterns
        do_write(18'h00000, 8'h3C);
        do_write(18'h3FFFF, 8'hFF);
        do_write(18'h00001, 8'hA5);
        do_write(18'h00002, 8'h5A);
        do_write(18'h12345, 8'h00);
        do_write(18'h2AAAA, 8'hC3);
        do_read(18'h00000);
        do_read(18'h3FFFF);
        do_read(18'h00001);
        do_read(18'h00002);
        do_read(18'h12345);
        do_read(18'h2AAAA);

        // R4 turnaround: alternate writes and reads back to back
        for (int i = 0; i < 8; i++) begin
            do_write(18'((i * 4099 + 7) & 18'h3FFFF), 8'(i * 37 + 1));
            do_read(18'((i * 4099 + 7) & 18'h3FFFF));
        end

        // R2 request held while busy must be ignored
        do_write(18'h00005, 8'h11);
        req_valid = 1; req_write = 1; req_addr = 18'h00005; req_wdata = 8'h99;
        repeat (3) @(negedge clk);
        check("R2 ready low while busy", req_ready, 0);
        req_valid = 0;
        do_read(18'h00005);

        do_write(18'h00001, 8'h77);
        do_read(18'h00001);
        do_read(18'h3FFFF);

        while (exp_q.size() != 0) @(negedge clk);
        repeat (12) @(negedge clk);
        check("R3/R4/R5 model timing violations", viol, 0);
        check("R4 drive during output enable", fights, 0);
        check("R1 idle after traffic", {req_ready, mem_cs1_n, mem_cs2, mem_dq_oe}, 4'b1100);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk + m_chk, n_err + m_err);
        $finish;
    end
endmodule